// File: doc/BRIEF.md
# GPIO Port with Interrupt-on-Change and Capture

This block is the port and interrupt core of a bidirectional general-purpose I/O bank, eight pins wide by default. Software sees a small register file through a single-cycle read/write port. It sets the direction of each pin, an input inversion mask, a pull-up mask and the output latch. It also programs the interrupt-on-change logic: a per-pin enable, a per-pin comparison mode and a per-pin reference level. Pin inputs are taken in asynchronously and pass through a two-flop synchronizer before anything else looks at them.

An enabled pin can raise an interrupt in one of two ways. It can compare its synchronized level with the level it had one clock earlier, so any edge counts. Or it can compare its level with a programmed reference bit, so any level opposite to the reference counts. When the first cause arrives while no flag is pending, the block stores the flagged pins and a snapshot of the readable port value. Both stay frozen until software reads the port or the snapshot. That read clears the flags. If a reference mismatch is still present at that moment, the flags are set again on the same edge.

The interrupt pin shows whether any flag is pending. Its active level is chosen by a control bit.

Top module: `gpio_ioc_core`

## Requirements
- R1: After reset the direction register reads 0xFF (all pins inputs, every `pin_oe` bit 0), all other writable registers read 0x00, and `irq` is high, because the default interrupt level is active-low.
- R2: A read of address 0x09 returns the synchronized pins XOR the inversion mask at address 0x01. A pin change shows up in that read two rising edges after it is applied.
- R3: A write to address 0x09 or 0x0A loads the output latch. A read of 0x0A returns the latch, `pin_out` equals the latch, and `pin_oe[i]` is the inverse of direction bit i (direction 1 = input).
- R4: A pin with its enable bit (address 0x02) set and its mode bit (address 0x04) clear raises its flag (address 0x07) on the third rising edge after its level changes.
- R5: A pin with enable and mode bits set raises its flag while its level differs from its reference bit (address 0x03). While the level equals the reference bit, it raises no flag.
- R6: A pin whose enable bit is clear never raises a flag, whatever its level does.
- R7: At capture the snapshot (address 0x08) stores the readable port value, inversion included. Flags and snapshot then hold, with no change from later pin activity, until they are cleared.
- R8: A read of 0x09 or 0x08 clears the flags on the next edge. A reference mismatch still present at that edge sets its flag again at once.
- R9: `irq` is asserted while any flag is set. Control bit 1 (address 0x05) set makes it active-high; clear makes it active-low.
- R10: Writes to the flag and snapshot addresses have no effect. Addresses above 0x0A read 0x00.
- R11: The pull-up mask at address 0x06 reads back as written and drives `pull_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers clear side effects) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output latch driven to the pins |
| pin_oe | output | 8 | Per-pin output enable (1 = driven) |
| pull_en | output | 8 | Per-pin pull-up enable |
| irq | output | 1 | Interrupt, level set by control bit 1 |

## Verification
The hardest situation to reach from the ports is a clear that lands on the same edge as a standing reference mismatch. The flags must drop and rise again within one edge, so `irq` never deasserts and the flag register reads the same value before and after the clearing read. The stimulus gets there by leaving a pin opposite its reference level and enabling it last. It then reads the snapshot, which clears the flags while the mismatch persists, and reads the flags again straight afterwards. A second hard case is showing that the snapshot is frozen. A pin is toggled back after the capture, and the stored flags and snapshot are compared with their earlier values before any clearing read.

// File: rtl/gpio_ioc_pkg.sv
// Shared definitions for the GPIO interrupt-on-change core.
// Assumes a 4-bit register address; register data width is set per instance.
package gpio_ioc_pkg;

    typedef enum logic [3:0] {
        RA_DIR    = 4'h0,
        RA_INV    = 4'h1,
        RA_IEN    = 4'h2,
        RA_REFV   = 4'h3,
        RA_CMPSEL = 4'h4,
        RA_CTRL   = 4'h5,
        RA_PULL   = 4'h6,
        RA_FLAG   = 4'h7,
        RA_SNAP   = 4'h8,
        RA_PORT   = 4'h9,
        RA_LATCH  = 4'hA
    } reg_sel_e;

    localparam int CTRL_IRQ_HI_BIT = 1;

endpackage

// File: rtl/gpio_ioc_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_ioc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Sample the raw pins into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Shift the sample through the following stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_ioc_regs.sv
// Software-writable configuration registers and output latch.
// Assumes single-cycle writes. Writes to the port address go to the latch.
// Read-only and unmapped addresses are ignored.
module gpio_ioc_regs
    import gpio_ioc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] inv_q,
    output logic [WIDTH-1:0] ien_q,
    output logic [WIDTH-1:0] refv_q,
    output logic [WIDTH-1:0] cmpsel_q,
    output logic [WIDTH-1:0] pull_q,
    output logic [WIDTH-1:0] latch_q,
    output logic             irq_hi_q
);
    // Decode one write strobe per register.
    logic wr_dir, wr_inv, wr_ien, wr_refv, wr_cmp, wr_ctrl, wr_pull, wr_lat;

    // Address decode for writes.
    always_comb begin
        wr_dir  = wr_en && (addr == RA_DIR);
        wr_inv  = wr_en && (addr == RA_INV);
        wr_ien  = wr_en && (addr == RA_IEN);
        wr_refv = wr_en && (addr == RA_REFV);
        wr_cmp  = wr_en && (addr == RA_CMPSEL);
        wr_ctrl = wr_en && (addr == RA_CTRL);
        wr_pull = wr_en && (addr == RA_PULL);
        wr_lat  = wr_en && ((addr == RA_LATCH) || (addr == RA_PORT));
    end

    // Direction register; resets to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (wr_dir) dir_q <= wdata;
    end

    // Input inversion mask.
    always_ff @(posedge clk) begin
        if (!rst_n)      inv_q <= '0;
        else if (wr_inv) inv_q <= wdata;
    end

    // Interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_ien) ien_q <= wdata;
    end

    // Reference levels for the compare-with-reference mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       refv_q <= '0;
        else if (wr_refv) refv_q <= wdata;
    end

    // Per-pin compare mode select.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmpsel_q <= '0;
        else if (wr_cmp) cmpsel_q <= wdata;
    end

    // Interrupt level control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_hi_q <= 1'b0;
        else if (wr_ctrl) irq_hi_q <= wdata[CTRL_IRQ_HI_BIT];
    end

    // Pull-up mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       pull_q <= '0;
        else if (wr_pull) pull_q <= wdata;
    end

    // Output latch, written through either the port or the latch address.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (wr_lat) latch_q <= wdata;
    end

    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == RA_PORT)) |=> (latch_q == $past(wdata)));

endmodule

// File: rtl/gpio_ioc_detect.sv
// Change detection, flag latching and port snapshot.
// Assumes pin levels are already synchronized. The previous-level
// reference updates every clock. Flags are taken only when none are
// pending or on a clearing edge, so the first cause is preserved.
module gpio_ioc_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_s,
    input  logic [WIDTH-1:0] inv,
    input  logic [WIDTH-1:0] ien,
    input  logic [WIDTH-1:0] refv,
    input  logic [WIDTH-1:0] cmpsel,
    input  logic             clr,
    output logic [WIDTH-1:0] port_val,
    output logic [WIDTH-1:0] flag_q,
    output logic [WIDTH-1:0] snap_q
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] hit;
    logic             take;

    assign port_val = pin_s ^ inv;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            // Per-pin mismatch against reference level or previous level.
            always_comb begin
                if (cmpsel[i]) hit[i] = ien[i] && (pin_s[i] != refv[i]);
                else           hit[i] = ien[i] && (pin_s[i] != prev_q[i]);
            end
        end
    endgenerate

    // A new cause is accepted when idle or when a clear is in progress.
    assign take = clr || (flag_q == '0);

    // Previous-level reference, refreshed every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_s;
    end

    // Flag register: load new causes or hold the pending ones.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_q <= '0;
        else if (take) flag_q <= hit;
    end

    // Snapshot of the readable port at capture time.
    always_ff @(posedge clk) begin
        if (!rst_n)                    snap_q <= '0;
        else if (take && (hit != '0))  snap_q <= port_val;
    end

    // R6
    flag_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q != $past(flag_q)) |-> ((flag_q & ~$past(ien)) == '0));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q != '0) && !clr) |=> $stable(flag_q));

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q != '0) && !clr) |=> $stable(snap_q));

    // R8
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (hit == '0)) |=> (flag_q == '0));

endmodule

// File: rtl/gpio_ioc_core.sv
// Top of the GPIO port and interrupt-on-change core.
// Assumes a single-cycle register port: rdata is combinational from addr,
// and rd_en marks a real read whose side effects (flag clear) take effect
// on the following rising edge.
module gpio_ioc_core
    import gpio_ioc_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [3:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pull_en,
    output logic             irq
);
    logic [WIDTH-1:0] pin_s;
    logic [WIDTH-1:0] dir_q, inv_q, ien_q, refv_q, cmpsel_q, pull_q, latch_q;
    logic             irq_hi_q;
    logic [WIDTH-1:0] port_val, flag_q, snap_q;
    logic [WIDTH-1:0] ctrl_rd;
    logic             clr;
    logic             pending;

    gpio_ioc_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .d_sync  (pin_s)
    );

    gpio_ioc_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .dir_q    (dir_q),
        .inv_q    (inv_q),
        .ien_q    (ien_q),
        .refv_q   (refv_q),
        .cmpsel_q (cmpsel_q),
        .pull_q   (pull_q),
        .latch_q  (latch_q),
        .irq_hi_q (irq_hi_q)
    );

    // Reading the port or the snapshot clears pending flags.
    assign clr = rd_en && ((addr == RA_PORT) || (addr == RA_SNAP));

    gpio_ioc_detect #(.WIDTH(WIDTH)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .inv      (inv_q),
        .ien      (ien_q),
        .refv     (refv_q),
        .cmpsel   (cmpsel_q),
        .clr      (clr),
        .port_val (port_val),
        .flag_q   (flag_q),
        .snap_q   (snap_q)
    );

    // Control register read image: only the level bit is implemented.
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CTRL_IRQ_HI_BIT] = irq_hi_q;
    end

    // Read data multiplexer.
    always_comb begin
        case (addr)
            RA_DIR:    rdata = dir_q;
            RA_INV:    rdata = inv_q;
            RA_IEN:    rdata = ien_q;
            RA_REFV:   rdata = refv_q;
            RA_CMPSEL: rdata = cmpsel_q;
            RA_CTRL:   rdata = ctrl_rd;
            RA_PULL:   rdata = pull_q;
            RA_FLAG:   rdata = flag_q;
            RA_SNAP:   rdata = snap_q;
            RA_PORT:   rdata = port_val;
            RA_LATCH:  rdata = latch_q;
            default:   rdata = '0;
        endcase
    end

    // Pin drive and interrupt level.
    assign pending = (flag_q != '0);
    assign pin_out = latch_q;
    assign pin_oe  = ~dir_q;
    assign pull_en = pull_q;
    assign irq     = irq_hi_q ? pending : ~pending;

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_q) == '0 && flag_q != '0 && $stable(irq_hi_q)) |-> (irq != $past(irq)));

endmodule

// File: tb/gpio_ioc_core_bench.sv
// Directed bench for gpio_ioc_core: one task per scenario.
module gpio_ioc_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe, pull_en;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    gpio_ioc_core u_gpio_ioc_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pull_en(pull_en), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'h0, v); check("R1 dir reset", v, 8'hFF);
        check("R1 pin_oe reset", pin_oe, 8'h00);
        check("R1 irq idle", {7'b0, irq}, 8'h01);
        rd(4'h1, v); check("R1 inv reset", v, 8'h00);
        rd(4'h5, v); check("R1 ctrl reset", v, 8'h00);
        check("R1 pull reset", pull_en, 8'h00);
    endtask

    task automatic t_port_inv();
        logic [7:0] v;
        @(negedge clk); pin_in = 8'h5A;
        tick(2);
        #1 addr = 4'h9; #1 check("R2 port after two edges", rdata, 8'h5A);
        wr(4'h1, 8'h0F);
        rd(4'h9, v); check("R2 port inverted", v, 8'h55);
        wr(4'h1, 8'h00);
    endtask

    task automatic t_latch();
        logic [7:0] v;
        wr(4'h0, 8'hF0);
        wr(4'h9, 8'h3C);
        rd(4'hA, v); check("R3 latch via port write", v, 8'h3C);
        check("R3 pin_out", pin_out, 8'h3C);
        check("R3 pin_oe", pin_oe, 8'h0F);
        rd(4'h9, v); check("R3 port reads pins not latch", v, 8'h5A);
        wr(4'hA, 8'hC1);
        check("R3 pin_out latch write", pin_out, 8'hC1);
    endtask

    task automatic t_prev();
        logic [7:0] v;
        @(negedge clk); pin_in = 8'h00;
        tick(4);
        wr(4'h1, 8'h80);
        wr(4'h4, 8'h00);
        wr(4'h2, 8'h01);
        @(negedge clk); pin_in = 8'h01;
        tick(2);
        check("R4 no flag before third edge", {7'b0, irq}, 8'h01);
        tick(1);
        check("R4 irq after third edge", {7'b0, irq}, 8'h00);
        rd(4'h7, v); check("R4 flag bit", v, 8'h01);
        rd(4'h7, v);
        @(negedge clk); pin_in = 8'h00;
        tick(4);
        rd(4'h7, v); check("R7 flags held", v, 8'h01);
        @(negedge clk); addr = 4'h8; #1 check("R7 snapshot with inversion", rdata, 8'h81);
        rd(4'h9, v);
        check("R8 irq released after port read", {7'b0, irq}, 8'h01);
        rd(4'h7, v); check("R8 flags cleared", v, 8'h00);
        wr(4'h1, 8'h00);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        @(negedge clk); pin_in = 8'h02;
        tick(4);
        @(negedge clk); pin_in = 8'h00;
        tick(4);
        check("R6 disabled pin no irq", {7'b0, irq}, 8'h01);
        rd(4'h7, v); check("R6 disabled pin no flag", v, 8'h00);
    endtask

    task automatic t_default();
        logic [7:0] v;
        wr(4'h3, 8'h04);
        wr(4'h4, 8'h04);
        wr(4'h2, 8'h04);
        tick(1);
        check("R5 reference mismatch irq", {7'b0, irq}, 8'h00);
        rd(4'h7, v); check("R5 reference flag", v, 8'h04);
        rd(4'h8, v);
        rd(4'h7, v); check("R8 flag re-set while mismatch", v, 8'h04);
        check("R8 irq stays asserted", {7'b0, irq}, 8'h00);
        @(negedge clk); pin_in = 8'h04;
        tick(3);
        rd(4'h9, v);
        tick(3);
        rd(4'h7, v); check("R5 equal level no flag", v, 8'h00);
        check("R5 irq idle when equal", {7'b0, irq}, 8'h01);
    endtask

    task automatic t_polarity();
        logic [7:0] v;
        wr(4'h5, 8'h02);
        check("R9 active-high idle", {7'b0, irq}, 8'h00);
        @(negedge clk); pin_in = 8'h00;
        tick(3);
        check("R9 active-high asserted", {7'b0, irq}, 8'h01);
        wr(4'h5, 8'h00);
        check("R9 active-low asserted", {7'b0, irq}, 8'h00);
        @(negedge clk); pin_in = 8'h04;
        tick(3);
        rd(4'h9, v);
        check("R9 active-low released", {7'b0, irq}, 8'h01);
    endtask

    task automatic t_readonly();
        logic [7:0] v, s;
        rd(4'h8, s);
        wr(4'h7, 8'hFF);
        rd(4'h7, v); check("R10 flag write ignored", v, 8'h00);
        check("R10 irq unaffected", {7'b0, irq}, 8'h01);
        wr(4'h8, 8'hFF);
        rd(4'h8, v); check("R10 snapshot write ignored", v, s);
        wr(4'hC, 8'hFF);
        rd(4'hC, v); check("R10 unmapped reads zero", v, 8'h00);
        wr(4'h6, 8'hA5);
        rd(4'h6, v); check("R11 pull readback", v, 8'hA5);
        check("R11 pull_en", pull_en, 8'hA5);
    endtask

    initial begin
        tick(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_port_inv();
        t_latch();
        t_prev();
        t_disabled();
        t_default();
        t_polarity();
        t_readonly();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got 0x00 expected 0x01");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule